// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits in front of a set of derived clock outputs and decides, output by output, whether each one runs or is held low. There are three groups of outputs: processor clocks, bus clocks, and free clocks that never respond to the stop pins. An output runs only when two things allow it. The first is its own enable bit from the serial control registers. The second, for the processor and bus groups, is an active-low hardware stop pin that is not asserted.

A strap input can switch the stop pins out of the decision, so that only the register bits matter. Every run/stop decision is made in the domain of a free-running reference clock and then handed to the gated clock. The handover happens on that clock's falling edge, so the output can only start or stop while it is low. No output ever shows a shortened high pulse or a runt pulse.

Top module: `glitchless_clk_stop`

## Requirements
- R1: An output that is stopped stays at logic 0 for as long as it is stopped.
- R2: Every rising and falling edge of an output coincides with the same edge of its source clock. No high pulse is shortened when the output stops, and no runt appears when it restarts.
- R3: A stop-pin change passes through a two-stage synchronizer, is registered on a rising edge of `refClk`, and then waits for a falling edge of the target clock. After a pin change, an output keeps its previous state for at least two full `refClk` periods.
- R4: An output with its bit of `regEnable` at 0 is stopped, whatever the stop pins and the strap say.
- R5: With `pinsBypass` = 0 and `cpuStopN` = 0, all processor outputs are stopped. With `cpuStopN` = 1, they follow their register bits.
- R6: With `pinsBypass` = 0 and `pciStopN` = 0, all bus outputs are stopped. With `pciStopN` = 1, they follow their register bits.
- R7: Free outputs follow only their register bits and ignore both stop pins in every combination.
- R8: With `pinsBypass` = 1, both stop pins have no effect, and every output follows its register bit.
- R9: `regEnable` bit i drives output i. Bits [NUM_CPU-1:0] map to the processor outputs, the next NUM_PCI bits map to the bus outputs, and the top NUM_FREE bits map to the free outputs. With all bits at 1 and both pins high after reset, every output runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock that times every gating decision |
| rstN | input | 1 | Asynchronous active-low reset; decisions reset to "run" |
| cpuClkIn | input | NUM_CPU | Ungated processor clocks |
| pciClkIn | input | NUM_PCI | Ungated bus clocks |
| freeClkIn | input | NUM_FREE | Ungated clocks that ignore the stop pins |
| cpuStopN | input | 1 | Active-low stop request for the processor group |
| pciStopN | input | 1 | Active-low stop request for the bus group |
| pinsBypass | input | 1 | 1 = stop pins ignored, 0 = stop pins in use |
| regEnable | input | NUM_CPU+NUM_PCI+NUM_FREE | Per-output run enable from the control registers |
| cpuClkOut | output | NUM_CPU | Gated processor clocks |
| pciClkOut | output | NUM_PCI | Gated bus clocks |
| freeClkOut | output | NUM_FREE | Gated free clocks |

## Verification
The bench builds the block with two processor outputs, three bus outputs, two free outputs and a two-stage synchronizer. With more than one output per group, a wrong bit mapping in `regEnable` or a group decision leaking onto its neighbour becomes visible. The three source clocks have periods of 6, 10 and 14 ns and are phase-shifted against the 10 ns reference. Because of this, gating changes land at many points of each target's cycle, and every edge of every output is compared with its source on a 1 ns grid.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    GRP_CPU  = 2'd0,
    GRP_PCI  = 2'd1,
    GRP_FREE = 2'd2
  } clkGroup_e;

  // Strobes from control to datapath, in the refClk domain.
  typedef struct packed {
    logic cpuAllow;
    logic pciAllow;
  } allowStrobes_t;

  function automatic clkGroup_e groupOf(input int idx, input int nCpu, input int nPci);
    if (idx < nCpu) return GRP_CPU;
    if (idx < nCpu + nPci) return GRP_PCI;
    return GRP_FREE;
  endfunction

endpackage

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          refClk,
  input  logic          rstN,
  input  logic          cpuStopN,
  input  logic          pciStopN,
  input  logic          pinsBypass,
  output allowStrobes_t allow
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cpuSync;
  logic [LAST:0] pciSync;

  // Stop pins resynchronized; reset value means "not stopping".
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cpuSync <= '1;
      pciSync <= '1;
    end else begin
      cpuSync <= {cpuSync[LAST-1:0], cpuStopN};
      pciSync <= {pciSync[LAST-1:0], pciStopN};
    end
  end

  always_comb begin
    allow.cpuAllow = pinsBypass | cpuSync[LAST];
    allow.pciAllow = pinsBypass | pciSync[LAST];
  end

endmodule

// File: rtl/clkstop_datapath.sv
module clkstop_datapath
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU  = 2,
  parameter int NUM_PCI  = 3,
  parameter int NUM_FREE = 2,
  localparam int NUM_ALL = NUM_CPU + NUM_PCI + NUM_FREE
) (
  input  logic               refClk,
  input  logic               rstN,
  input  allowStrobes_t      allow,
  input  logic [NUM_ALL-1:0] regEnable,
  input  logic [NUM_ALL-1:0] clkIn,
  output logic [NUM_ALL-1:0] runReq,
  output logic [NUM_ALL-1:0] clkOut
);

  for (genvar i = 0; i < NUM_ALL; i++) begin : g_lane
    localparam clkGroup_e GRP = groupOf(i, NUM_CPU, NUM_PCI);

    logic groupOk;
    logic reqQ;
    logic enHold;

    if (GRP == GRP_CPU) begin : g_cpu
      assign groupOk = allow.cpuAllow;
    end else if (GRP == GRP_PCI) begin : g_pci
      assign groupOk = allow.pciAllow;
    end else begin : g_free
      assign groupOk = 1'b1;
    end

    // Decision taken on a reference rising edge.
    always_ff @(posedge refClk or negedge rstN) begin
      if (!rstN) reqQ <= 1'b1;
      else       reqQ <= regEnable[i] & groupOk;
    end

    // Handed over on the target's falling edge, so it only changes while low.
    always_ff @(negedge clkIn[i]) begin
      enHold <= reqQ;
    end

    assign runReq[i] = reqQ;
    assign clkOut[i] = clkIn[i] & enHold;
  end

endmodule

// File: rtl/glitchless_clk_stop.sv
module glitchless_clk_stop
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU     = 2,
  parameter int NUM_PCI     = 3,
  parameter int NUM_FREE    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_ALL    = NUM_CPU + NUM_PCI + NUM_FREE
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic [NUM_CPU-1:0]  cpuClkIn,
  input  logic [NUM_PCI-1:0]  pciClkIn,
  input  logic [NUM_FREE-1:0] freeClkIn,
  input  logic                cpuStopN,
  input  logic                pciStopN,
  input  logic                pinsBypass,
  input  logic [NUM_ALL-1:0]  regEnable,
  output logic [NUM_CPU-1:0]  cpuClkOut,
  output logic [NUM_PCI-1:0]  pciClkOut,
  output logic [NUM_FREE-1:0] freeClkOut
);

  allowStrobes_t      allow;
  logic [NUM_ALL-1:0] clkAll;
  logic [NUM_ALL-1:0] outAll;
  logic [NUM_ALL-1:0] runReq;

  assign clkAll = {freeClkIn, pciClkIn, cpuClkIn};

  clkstop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .cpuStopN  (cpuStopN),
    .pciStopN  (pciStopN),
    .pinsBypass(pinsBypass),
    .allow     (allow)
  );

  clkstop_datapath #(
    .NUM_CPU (NUM_CPU),
    .NUM_PCI (NUM_PCI),
    .NUM_FREE(NUM_FREE)
  ) u_dp (
    .refClk   (refClk),
    .rstN     (rstN),
    .allow    (allow),
    .regEnable(regEnable),
    .clkIn    (clkAll),
    .runReq   (runReq),
    .clkOut   (outAll)
  );

  assign cpuClkOut  = outAll[NUM_CPU-1:0];
  assign pciClkOut  = outAll[NUM_CPU+NUM_PCI-1:NUM_CPU];
  assign freeClkOut = outAll[NUM_ALL-1:NUM_CPU+NUM_PCI];

endmodule

// File: rtl/clkstop_checker.sv
module clkstop_checker #(
  parameter int NUM_CPU  = 2,
  parameter int NUM_PCI  = 3,
  parameter int NUM_FREE = 2,
  localparam int NUM_ALL = NUM_CPU + NUM_PCI + NUM_FREE
) (
  input logic               refClk,
  input logic               rstN,
  input logic               cpuStopN,
  input logic               pciStopN,
  input logic               pinsBypass,
  input logic [NUM_ALL-1:0] regEnable,
  input logic [NUM_ALL-1:0] runReq
);

  logic [1:0] sinceRst;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)               sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R5: pin held low long enough to cross the synchronizer stops the processor group
  a_r5_cpu_held: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst == 2'd3 && !pinsBypass && !$past(pinsBypass) && !$past(pinsBypass, 2) &&
     !cpuStopN && !$past(cpuStopN) && !$past(cpuStopN, 2))
    |=> (runReq[NUM_CPU-1:0] == '0));

  // R6: same for the bus group
  a_r6_pci_held: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst == 2'd3 && !pinsBypass && !$past(pinsBypass) && !$past(pinsBypass, 2) &&
     !pciStopN && !$past(pciStopN) && !$past(pciStopN, 2))
    |=> (runReq[NUM_CPU+NUM_PCI-1:NUM_CPU] == '0));

  // R4: a cleared register bit never yields a run decision
  a_r4_reg_gate: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst != 2'd0) |-> ((runReq & ~$past(regEnable)) == '0));

  // R7: free group tracks only its register bits
  a_r7_free_follow: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst != 2'd0) |->
    (runReq[NUM_ALL-1:NUM_CPU+NUM_PCI] == $past(regEnable[NUM_ALL-1:NUM_CPU+NUM_PCI])));

  // R8: with the pins bypassed, decisions equal the register bits
  a_r8_bypass: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst != 2'd0 && $past(pinsBypass)) |-> (runReq == $past(regEnable)));

endmodule

bind glitchless_clk_stop clkstop_checker #(
  .NUM_CPU (NUM_CPU),
  .NUM_PCI (NUM_PCI),
  .NUM_FREE(NUM_FREE)
) u_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .cpuStopN  (cpuStopN),
  .pciStopN  (pciStopN),
  .pinsBypass(pinsBypass),
  .regEnable (regEnable),
  .runReq    (runReq)
);

// File: tb/glitchless_clk_stop_bench.sv
`timescale 1ns/100ps
module glitchless_clk_stop_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NP = 3;
  localparam int NF = 2;
  localparam int NA = NC + NP + NF;

  logic refClk, rstN;
  logic [NC-1:0] cpuClk;
  logic [NP-1:0] pciClk;
  logic [NF-1:0] freeClk;
  logic cpuStopN, pciStopN, pinsBypass;
  logic [NA-1:0] regEnable;
  logic [NC-1:0] cpuOut;
  logic [NP-1:0] pciOut;
  logic [NF-1:0] freeOut;

  glitchless_clk_stop #(.NUM_CPU(NC), .NUM_PCI(NP), .NUM_FREE(NF), .SYNC_STAGES(2)) u_glitchless_clk_stop (
    .refClk(refClk), .rstN(rstN), .cpuClkIn(cpuClk), .pciClkIn(pciClk), .freeClkIn(freeClk),
    .cpuStopN(cpuStopN), .pciStopN(pciStopN), .pinsBypass(pinsBypass), .regEnable(regEnable),
    .cpuClkOut(cpuOut), .pciClkOut(pciOut), .freeClkOut(freeOut)
  );

  wire [NA-1:0] srcAll = {freeClk, pciClk, cpuClk};
  wire [NA-1:0] outAll = {freeOut, pciOut, cpuOut};

  int checks = 0;
  int errors = 0;
  int runts = 0, truncs = 0, glitches = 0;
  bit finished = 0;
  logic [NA-1:0] activity;

  typedef struct { logic [NA-1:0] exp; string tag; } sbItem_t;
  sbItem_t sbQ[$];
  event winStart, winDone;

  // Clocks
  initial begin refClk = 0; forever #(CLK_PERIOD/2) refClk = ~refClk; end
  initial begin cpuClk = '0; forever #3 cpuClk = ~cpuClk; end
  initial begin pciClk = '0; #2; forever #5 pciClk = ~pciClk; end
  initial begin freeClk = '0; forever #7 freeClk = ~freeClk; end

  // Edge monitor on a 1 ns grid, sampling half-way between edges (R2, R1)
  initial begin
    logic [NA-1:0] prevSrc, prevOut;
    activity = '0;
    #0.5;
    prevSrc = srcAll;
    prevOut = outAll;
    forever begin
      #1;
      if (rstN) begin
        for (int i = 0; i < NA; i++) begin
          if (outAll[i] && !srcAll[i]) glitches++;
          if (outAll[i] && !prevOut[i] && !(srcAll[i] && !prevSrc[i])) runts++;
          if (!outAll[i] && prevOut[i] && !(!srcAll[i] && prevSrc[i])) truncs++;
        end
      end
      activity = activity | outAll;
      prevSrc = srcAll;
      prevOut = outAll;
    end
  end

  // Scoreboard monitor: observe a window, pop the expected item, compare
  initial begin
    sbItem_t it;
    forever begin
      @(winStart);
      activity = '0;
      #30;
      it = sbQ.pop_front();
      checks++;
      if (activity !== it.exp) begin
        errors++;
        $display("FAIL %s: running outputs actual=%b expected=%b", it.tag, activity, it.exp);
      end
      ->winDone;
    end
  end

  function automatic logic [NA-1:0] expFor(input logic cS, input logic pS,
                                           input logic md, input logic [NA-1:0] en);
    logic [NA-1:0] r;
    for (int i = 0; i < NA; i++) begin
      if (i < NC)           r[i] = en[i] & (md | cS);
      else if (i < NC + NP) r[i] = en[i] & (md | pS);
      else                  r[i] = en[i];
    end
    return r;
  endfunction

  task automatic applyCase(input logic cS, input logic pS, input logic md,
                           input logic [NA-1:0] en, input string tag);
    sbItem_t it;
    cpuStopN = cS; pciStopN = pS; pinsBypass = md; regEnable = en;
    #80;
    it.exp = expFor(cS, pS, md, en);
    it.tag = tag;
    sbQ.push_back(it);
    ->winStart;
    @(winDone);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    logic [NC-1:0] seen;
    rstN = 0; cpuStopN = 1; pciStopN = 1; pinsBypass = 0; regEnable = '1;
    repeat (5) @(posedge refClk);
    #0.5;
    rstN = 1;
    @(posedge refClk);
    #0.5;

    applyCase(1, 1, 0, '1,           "R9 reset default all run");
    applyCase(0, 1, 0, '1,           "R5/R1 cpu stop");
    applyCase(0, 0, 0, '1,           "R6/R7 both pins low");
    applyCase(1, 0, 0, '1,           "R6 pci stop only");
    applyCase(0, 0, 1, '1,           "R8 pins bypassed");
    applyCase(0, 0, 1, 7'b0111010,   "R4/R9 bit mapping under bypass");
    applyCase(1, 1, 0, 7'b1010101,   "R4 register bits with pins high");
    applyCase(0, 0, 0, 7'b0111111,   "R7/R4 free bit cleared, pins low");
    applyCase(1, 1, 0, '1,           "R2 restart all");

    // R3: stop must not reach the outputs before two reference periods
    @(posedge refClk); #0.5;
    cpuStopN = 0;
    seen = '0;
    for (int k = 0; k < 18; k++) begin #1; seen = seen | cpuOut; end
    checkVal("R3 cpu still running after stop request", int'(seen), int'({NC{1'b1}}));
    #60;
    // R3: restart must not reach the outputs before two reference periods
    @(posedge refClk); #0.5;
    cpuStopN = 1;
    seen = '0;
    for (int k = 0; k < 18; k++) begin #1; seen = seen | cpuOut; end
    checkVal("R3 cpu still stopped after release", int'(seen), 0);
    #80;

    checkVal("R2 runt pulses", runts, 0);
    checkVal("R2 truncated pulses", truncs, 0);
    checkVal("R2 output high while source low", glitches, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule